// File: doc/BRIEF.md
# DSP Serial Link Port

This block ends one DSP's frame-synchronised serial link on the router side of a switch fabric. Every block of data opens with a 32-bit header word that names the sender, the destination and how many data words follow. The port decodes this header and puts a request to the allocation router. It waits for the router's decision and sends a reply word back to the DSP on its own transmit link. If space was granted, it then writes the accepted number of data words into the chosen FIFO.

Both serial directions carry 32-bit words, most significant bit first. A frame-sync bit period comes before each word. The receive side samples its clock, frame-sync and data into the system clock domain. The transmit side makes its bit clock by dividing the system clock. The router may grant fewer words than were asked for. The DSP still sends the full block, and the port throws away the surplus. A WAIT answer sends the port back to idle, and the DSP must send the header again.

Top module: `dsp_link_port`

## Requirements
- R1: While rst_ni is low and right after reset: req_o, fifo_wr_o, tx_fs_o and tx_sd_o are all 0.
- R2: A receive word starts when rx_fs_i is high at a rising rx_sclk_i edge. The next 32 rising edges then deliver the word, MSB first, on rx_sd_i.
- R3: The header word is decoded as source = bits 31:28, target = bits 27:24, count = bits 23:16. Bits 15:0 have no effect. req_o stays high with req_src_o, req_target_o and req_count_o stable until a cycle in which rsp_valid_i is high, and then falls.
- R4: No FIFO write takes place from the start of the header until the reply word has been fully sent.
- R5: The accepted count is rsp_count_i, limited to the requested count. When it equals the requested count, the reply word is 0x0000_0001.
- R6: When the accepted count is 0 and the requested count is not 0, the reply is 0x0000_0000. The header is then dropped, and the next received word is treated as a new header.
- R7: When the accepted count NN lies strictly between 0 and the requested count, the reply is 0x8000_0000 | NN.
- R8: After the reply, the first NN received data words are written in order on fifo_data_o. Each write is a single one-cycle pulse on fifo_wr_o. The pulse is one-hot, and bit k is set when rsp_fifo_i was k at the decision.
- R9: Of a granted block, the port takes in exactly the requested count of data words. Words past the accepted count cause no write. The word after the block is decoded as a new header.
- R10: tx_sclk_o runs freely with a period of 2*TX_HALF system clocks. tx_fs_o is high for one bit period before the MSB of a reply. tx_sd_o and tx_fs_o change only on falling tx_sclk_o edges. tx_sd_o is 0 while tx_fs_o is high.
- R11: A header with count 0 gets the OK reply 0x0000_0001 and causes no FIFO write. The next word is a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_sclk_i | input | 1 | Receive bit clock from the DSP |
| rx_fs_i | input | 1 | Receive frame-sync |
| rx_sd_i | input | 1 | Receive serial data |
| tx_sclk_o | output | 1 | Transmit bit clock |
| tx_fs_o | output | 1 | Transmit frame-sync |
| tx_sd_o | output | 1 | Transmit serial data |
| req_o | output | 1 | Allocation request to the router |
| req_src_o | output | 4 | Source address from the header |
| req_target_o | output | 4 | Target address from the header |
| req_count_o | output | 8 | Requested word count |
| rsp_valid_i | input | 1 | Router decision valid |
| rsp_count_i | input | 8 | Words the router accepts (0 = wait) |
| rsp_fifo_i | input | $clog2(N_FIFO) | Index of the granted FIFO |
| fifo_wr_o | output | N_FIFO | One-hot FIFO write strobes |
| fifo_data_o | output | 32 | Data word to write |

## Verification
The header-to-write path is run under four kinds of router answer, and each one separates a different branch of the reply logic. A full grant checks the OK code and the complete run of writes. A partial grant of a longer block checks the flagged count and that the surplus words are dropped. A zero grant checks the WAIT code, that nothing is written, and that the resent header is accepted. An offer larger than the request checks that the grant is limited to the request. A zero-length header and headers with non-zero index and reserved bits check that only the defined fields reach the router. Each answer uses a different FIFO index, so a wrong strobe position is caught.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int CNT_W   = 8;
  localparam int SRC_LSB = 28;
  localparam int TGT_LSB = 24;
  localparam int CNT_LSB = 16;

  localparam logic [WORD_W-1:0] REPLY_OK   = 32'h0000_0001;
  localparam logic [WORD_W-1:0] REPLY_WAIT = 32'h0000_0000;
  localparam logic [WORD_W-1:0] REPLY_PART = 32'h8000_0000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_HDR,
    ST_REQ,
    ST_REPLY,
    ST_FWD,
    ST_DONE
  } link_st_e;
endpackage

// File: rtl/dlp_rx_deser.sv
module dlp_rx_deser
  import dlp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              fs_i,
  input  logic              sd_i,
  output logic              start_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int LAST  = SYNC_STAGES - 1;

  // per-line synchronizer chains: [0]=clk [1]=fs [2]=data
  logic [SYNC_STAGES-1:0] sync_q [3];
  logic [2:0] raw;
  assign raw = {sd_i, fs_i, sclk_i};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= '0;
      else         sync_q[g] <= {sync_q[g][SYNC_STAGES-2:0], raw[g]};
    end
  end

  logic sclk_s, fs_s, sd_s, sclk_d, rise;
  logic active_q;
  logic [BIT_W-1:0] bit_q;
  logic [WORD_W-1:0] shift_q;

  assign sclk_s = sync_q[0][LAST];
  assign fs_s   = sync_q[1][LAST];
  assign sd_s   = sync_q[2][LAST];
  assign rise   = sclk_s & ~sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      active_q <= 1'b0;
      bit_q    <= '0;
      shift_q  <= '0;
      start_o  <= 1'b0;
      valid_o  <= 1'b0;
      word_o   <= '0;
    end else begin
      sclk_d  <= sclk_s;
      start_o <= 1'b0;
      valid_o <= 1'b0;
      if (rise) begin
        if (active_q) begin
          shift_q <= {shift_q[WORD_W-2:0], sd_s};
          bit_q   <= bit_q + 1'b1;
          if (bit_q == BIT_W'(WORD_W - 1)) begin
            active_q <= 1'b0;
            valid_o  <= 1'b1;
            word_o   <= {shift_q[WORD_W-2:0], sd_s};
          end
        end
        // frame-sync re-arms, also mid-word
        if (fs_s) begin
          active_q <= 1'b1;
          bit_q    <= '0;
          start_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dlp_tx_ser.sv
module dlp_tx_ser
  import dlp_pkg::*;
#(
  parameter int TX_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sclk_o,
  output logic              fs_o,
  output logic              sd_o,
  output logic              done_o
);
  localparam int DIV_W = (TX_HALF > 1) ? $clog2(TX_HALF) : 1;
  localparam int POS_W = $clog2(WORD_W + 1);

  logic [DIV_W-1:0] div_q;
  logic             sclk_q, tick, fall;
  logic             pend_q, busy_q;
  logic [POS_W-1:0] pos_q;
  logic [WORD_W-1:0] sh_q;

  assign tick   = (div_q == DIV_W'(TX_HALF - 1));
  assign fall   = tick & sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      pos_q  <= '0;
      sh_q   <= '0;
      fs_o   <= 1'b0;
      sd_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !pend_q && !busy_q) begin
        pend_q <= 1'b1;
        sh_q   <= word_i;
      end
      if (fall) begin
        if (busy_q) begin
          fs_o <= 1'b0;
          if (pos_q == POS_W'(WORD_W)) begin
            sd_o   <= 1'b0;
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end else begin
            sd_o  <= sh_q[WORD_W-1];
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            pos_q <= pos_q + 1'b1;
          end
        end else if (pend_q) begin
          // one frame-sync bit period ahead of the MSB
          fs_o   <= 1'b1;
          sd_o   <= 1'b0;
          pend_q <= 1'b0;
          busy_q <= 1'b1;
          pos_q  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/dlp_ctrl.sv
module dlp_ctrl
  import dlp_pkg::*;
#(
  parameter int N_FIFO = 4,
  localparam int SEL_W = $clog2(N_FIFO)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_src_o,
  output logic [ADDR_W-1:0] req_target_o,
  output logic [CNT_W-1:0]  req_count_o,
  input  logic              rsp_valid_i,
  input  logic [CNT_W-1:0]  rsp_count_i,
  input  logic [SEL_W-1:0]  rsp_fifo_i,
  output logic              tx_start_o,
  output logic [WORD_W-1:0] tx_word_o,
  input  logic              tx_done_i,
  output logic [N_FIFO-1:0] fifo_wr_o,
  output logic [WORD_W-1:0] fifo_data_o
);
  link_st_e         st_q;
  logic [ADDR_W-1:0] src_q, tgt_q;
  logic [CNT_W-1:0]  cnt_q, grant_q, recv_q, acc;
  logic [SEL_W-1:0]  sel_q;
  logic              wait_q;

  assign acc          = (rsp_count_i > cnt_q) ? cnt_q : rsp_count_i;
  assign req_o        = (st_q == ST_REQ);
  assign req_src_o    = src_q;
  assign req_target_o = tgt_q;
  assign req_count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      src_q       <= '0;
      tgt_q       <= '0;
      cnt_q       <= '0;
      grant_q     <= '0;
      recv_q      <= '0;
      sel_q       <= '0;
      wait_q      <= 1'b0;
      tx_start_o  <= 1'b0;
      tx_word_o   <= '0;
      fifo_wr_o   <= '0;
      fifo_data_o <= '0;
    end else begin
      tx_start_o <= 1'b0;
      fifo_wr_o  <= '0;
      unique case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_GET_HDR;
        ST_GET_HDR: if (valid_i) begin
          src_q <= word_i[SRC_LSB +: ADDR_W];
          tgt_q <= word_i[TGT_LSB +: ADDR_W];
          cnt_q <= word_i[CNT_LSB +: CNT_W];
          st_q  <= ST_REQ;
        end
        ST_REQ: if (rsp_valid_i) begin
          tx_start_o <= 1'b1;
          sel_q      <= rsp_fifo_i;
          grant_q    <= acc;
          recv_q     <= cnt_q;
          if (acc == cnt_q) begin
            tx_word_o <= REPLY_OK;
            wait_q    <= 1'b0;
          end else if (acc == '0) begin
            tx_word_o <= REPLY_WAIT;
            wait_q    <= 1'b1;
          end else begin
            tx_word_o <= REPLY_PART | WORD_W'(acc);
            wait_q    <= 1'b0;
          end
          st_q <= ST_REPLY;
        end
        ST_REPLY: if (tx_done_i) begin
          if (wait_q)             st_q <= ST_IDLE;
          else if (cnt_q == '0)   st_q <= ST_DONE;
          else                    st_q <= ST_FWD;
        end
        ST_FWD: if (valid_i) begin
          if (grant_q != '0) begin
            fifo_wr_o   <= N_FIFO'(1) << sel_q;
            fifo_data_o <= word_i;
            grant_q     <= grant_q - 1'b1;
          end
          recv_q <= recv_q - 1'b1;
          if (recv_q == CNT_W'(1)) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsp_link_port.sv
module dsp_link_port
  import dlp_pkg::*;
#(
  parameter int N_FIFO      = 4,
  parameter int TX_HALF     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(N_FIFO)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_sclk_i,
  input  logic              rx_fs_i,
  input  logic              rx_sd_i,
  output logic              tx_sclk_o,
  output logic              tx_fs_o,
  output logic              tx_sd_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_src_o,
  output logic [ADDR_W-1:0] req_target_o,
  output logic [CNT_W-1:0]  req_count_o,
  input  logic              rsp_valid_i,
  input  logic [CNT_W-1:0]  rsp_count_i,
  input  logic [SEL_W-1:0]  rsp_fifo_i,
  output logic [N_FIFO-1:0] fifo_wr_o,
  output logic [WORD_W-1:0] fifo_data_o
);
  logic              rx_start, rx_valid, tx_start, tx_done;
  logic [WORD_W-1:0] rx_word, tx_word;

  dlp_rx_deser #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sclk_i(rx_sclk_i), .fs_i(rx_fs_i), .sd_i(rx_sd_i),
    .start_o(rx_start), .valid_o(rx_valid), .word_o(rx_word)
  );

  dlp_ctrl #(.N_FIFO(N_FIFO)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(rx_start), .valid_i(rx_valid), .word_i(rx_word),
    .req_o(req_o), .req_src_o(req_src_o), .req_target_o(req_target_o),
    .req_count_o(req_count_o),
    .rsp_valid_i(rsp_valid_i), .rsp_count_i(rsp_count_i), .rsp_fifo_i(rsp_fifo_i),
    .tx_start_o(tx_start), .tx_word_o(tx_word), .tx_done_i(tx_done),
    .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o)
  );

  dlp_tx_ser #(.TX_HALF(TX_HALF)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(tx_start), .word_i(tx_word),
    .sclk_o(tx_sclk_o), .fs_o(tx_fs_o), .sd_o(tx_sd_o), .done_o(tx_done)
  );
endmodule

// File: rtl/dlp_checker.sv
module dlp_checker #(
  parameter int N_FIFO = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_sclk_o,
  input logic              tx_fs_o,
  input logic              tx_sd_o,
  input logic              req_o,
  input logic [3:0]        req_src_o,
  input logic [3:0]        req_target_o,
  input logic [7:0]        req_count_o,
  input logic              rsp_valid_i,
  input logic [N_FIFO-1:0] fifo_wr_o
);
  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fifo_wr_o)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !rsp_valid_i |=> req_o && $stable(req_target_o) && $stable(req_count_o) && $stable(req_src_o)); // R3
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && rsp_valid_i |=> !req_o); // R3
  AST_NO_WR_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> fifo_wr_o == '0); // R4
  AST_TX_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_sclk_o) |-> $stable(tx_sd_o) && $stable(tx_fs_o)); // R10
  AST_FS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fs_o |-> !tx_sd_o); // R10
endmodule

bind dsp_link_port dlp_checker #(.N_FIFO(N_FIFO)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tx_sclk_o(tx_sclk_o), .tx_fs_o(tx_fs_o), .tx_sd_o(tx_sd_o),
  .req_o(req_o), .req_src_o(req_src_o), .req_target_o(req_target_o),
  .req_count_o(req_count_o), .rsp_valid_i(rsp_valid_i), .fifo_wr_o(fifo_wr_o)
);

// File: tb/sim_dsp_link_port.sv
module sim_dsp_link_port;
  localparam int N_FIFO  = 4;
  localparam int TX_HALF = 2;
  localparam int RX_HALF = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_sclk = 1'b0, rx_fs = 1'b0, rx_sd = 1'b0;
  logic tx_sclk, tx_fs, tx_sd, req;
  logic [3:0] req_src, req_tgt;
  logic [7:0] req_cnt;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_count = '0;
  logic [1:0] rsp_fifo = '0;
  logic [N_FIFO-1:0] fifo_wr;
  logic [31:0] fifo_data;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dsp_link_port #(.N_FIFO(N_FIFO), .TX_HALF(TX_HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .rx_sclk_i(rx_sclk), .rx_fs_i(rx_fs), .rx_sd_i(rx_sd),
    .tx_sclk_o(tx_sclk), .tx_fs_o(tx_fs), .tx_sd_o(tx_sd),
    .req_o(req), .req_src_o(req_src), .req_target_o(req_tgt), .req_count_o(req_cnt),
    .rsp_valid_i(rsp_valid), .rsp_count_i(rsp_count), .rsp_fifo_i(rsp_fifo),
    .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  // router model: answers each request after 3 cycles
  logic [7:0] rt_count = '0;
  logic [1:0] rt_fifo = '0;
  logic [3:0] cap_src, cap_tgt;
  logic [7:0] cap_cnt;
  int rt_wait = 0;
  always @(negedge clk) begin
    if (rsp_valid) rsp_valid = 1'b0;
    else if (req) begin
      if (rt_wait == 3) begin
        cap_src = req_src; cap_tgt = req_tgt; cap_cnt = req_cnt;
        rsp_count = rt_count; rsp_fifo = rt_fifo; rsp_valid = 1'b1;
        rt_wait = 0;
      end else rt_wait++;
    end
  end

  // reply monitor: frame-sync bit, then 32 bits on rising tx clock
  logic tx_prev = 1'b0, tx_arm = 1'b0;
  int tx_bits = 0, reply_n = 0;
  logic [31:0] tx_sh = '0, reply_w = '0;
  always @(negedge clk) begin
    if (tx_sclk && !tx_prev) begin
      if (tx_arm) begin
        tx_sh = {tx_sh[30:0], tx_sd};
        tx_bits++;
        if (tx_bits == 32) begin reply_w = tx_sh; reply_n++; tx_arm = 1'b0; end
      end else if (tx_fs) begin
        tx_arm = 1'b1; tx_bits = 0;
      end
    end
    tx_prev = tx_sclk;
  end

  // FIFO write log
  logic [31:0] log_d [256];
  logic [N_FIFO-1:0] log_s [256];
  int wr_n = 0;
  always @(negedge clk) begin
    if (|fifo_wr && wr_n < 256) begin
      log_d[wr_n] = fifo_data; log_s[wr_n] = fifo_wr; wr_n++;
    end
  end

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    rx_fs = 1'b1; rx_sd = 1'b0;
    repeat (RX_HALF) @(negedge clk); rx_sclk = 1'b1;
    repeat (RX_HALF) @(negedge clk); rx_sclk = 1'b0; rx_fs = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      rx_sd = w[i];
      repeat (RX_HALF) @(negedge clk); rx_sclk = 1'b1;
      repeat (RX_HALF) @(negedge clk); rx_sclk = 1'b0;
    end
    rx_sd = 1'b0;
    repeat (2 * RX_HALF) @(negedge clk);
  endtask

  function automatic logic [31:0] dword(input int tag, input int k);
    return 32'hC35A_0000 | (tag << 8) | k;
  endfunction

  // one block: header, router answer, reply check, data, write check
  task automatic run_block(input logic [3:0] src, input logic [3:0] tgt, input logic [7:0] cnt,
                           input logic [7:0] offer, input logic [1:0] fsel, input int n_send,
                           input logic [31:0] exp_reply, input int exp_wr, input int tag,
                           input string rq);
    int r0, w0, t;
    r0 = reply_n; w0 = wr_n;
    rt_count = offer; rt_fifo = fsel;
    send_word({src, tgt, cnt, 4'h9, 12'hE7B});
    t = 0;
    while (reply_n == r0 && t < 8000) begin @(negedge clk); t++; end
    chk(reply_n == r0 + 1, {rq, " reply sent"}, reply_n, r0 + 1);
    chk(reply_w == exp_reply, {rq, " reply code"}, reply_w, exp_reply);
    chk({cap_src, cap_tgt, cap_cnt} == {src, tgt, cnt}, "R3 header fields to router",
        {16'h0, cap_src, cap_tgt, cap_cnt}, {16'h0, src, tgt, cnt});
    chk(wr_n == w0, "R4 no write before reply", wr_n, w0);
    repeat (40) @(negedge clk);
    for (int k = 0; k < n_send; k++) send_word(dword(tag, k));
    repeat (20) @(negedge clk);
    chk(wr_n - w0 == exp_wr, "R8 R9 write count", wr_n - w0, exp_wr);
    for (int k = 0; k < exp_wr && (w0 + k) < 256; k++) begin
      chk(log_d[w0 + k] == dword(tag, k), "R8 write data order", log_d[w0 + k], dword(tag, k));
      chk(log_s[w0 + k] == N_FIFO'(1) << fsel, "R8 strobe select",
          32'(log_s[w0 + k]), 32'(N_FIFO'(1) << fsel));
    end
  endtask

  task automatic t_reset;
    int c, t;
    repeat (3) @(negedge clk);
    chk({req, fifo_wr, tx_fs, tx_sd} == '0, "R1 outputs in reset", {25'h0, req, fifo_wr, tx_fs, tx_sd}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk({req, fifo_wr, tx_fs, tx_sd} == '0, "R1 outputs after reset", {25'h0, req, fifo_wr, tx_fs, tx_sd}, 0);
    t = 0;
    while (!(tx_sclk && !tx_prev) && t < 100) begin @(negedge clk); t++; end
    @(negedge clk); c = 1;
    while (!(tx_sclk && !tx_prev) && c < 100) begin @(negedge clk); c++; end
    chk(c == 2 * TX_HALF, "R10 tx clock period", c, 2 * TX_HALF);
  endtask

  task automatic t_full;
    run_block(4'h3, 4'h5, 8'd4, 8'd4, 2'd2, 4, 32'h0000_0001, 4, 1, "R2 R5 full grant");
  endtask

  task automatic t_partial;
    run_block(4'hA, 4'h1, 8'd6, 8'd3, 2'd1, 6, 32'h8000_0003, 3, 2, "R7 partial grant");
    // R9: next word is a header again
    run_block(4'h2, 4'h7, 8'd2, 8'd2, 2'd3, 2, 32'h0000_0001, 2, 3, "R9 after drop");
  endtask

  task automatic t_wait;
    run_block(4'h6, 4'hC, 8'd5, 8'd0, 2'd0, 0, 32'h0000_0000, 0, 4, "R6 wait");
    run_block(4'h6, 4'hC, 8'd5, 8'd5, 2'd0, 5, 32'h0000_0001, 5, 5, "R6 resend");
  endtask

  task automatic t_clamp;
    run_block(4'hF, 4'h0, 8'd3, 8'd200, 2'd3, 3, 32'h0000_0001, 3, 6, "R5 clamp");
  endtask

  task automatic t_zero;
    run_block(4'h1, 4'h4, 8'd0, 8'd0, 2'd1, 0, 32'h0000_0001, 0, 7, "R11 zero count");
    run_block(4'h8, 4'h2, 8'd1, 8'd1, 2'd2, 1, 32'h0000_0001, 1, 8, "R11 next header");
  endtask

  initial begin
    t_reset();
    t_full();
    t_partial();
    t_wait();
    t_clamp();
    t_zero();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule